// File: doc/BRIEF.md
# Working Register Storage with Status Write-Back

This block is the storage half of a microcoded 16-bit datapath. It keeps thirty-two general working words, one accumulator and an 8-bit status word. Every cycle the execution logic presents a result, the arithmetic flags and a destination code. The block decides whether that result lands in the addressed working word, in the accumulator or nowhere, and whether the flags are captured.

Byte-mode instructions change only the low eight bits of the destination. Word-mode instructions change all sixteen. The zero flag is derived here from the result, at byte or word width. The status word loads only when the instruction enable and the status enable, both active low, are asserted together and the instruction is not a no-op. The stored carry is brought out on its own pin so that the carry-in selector of the arithmetic unit can use it.

The design has no state machine. The house-style headings for states and transitions therefore have no counterpart here.

Top module: `rfs_storage`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and the status word to zero, so `carry_o` reads 0. Reset takes priority over any write in the same cycle.
- R2: When `ien_n_i` is 0 and `dest_sel_i` is 2'b01, the working word at `reg_addr_i` is written on the rising clock edge. `reg_rd_o` shows the addressed word combinationally, and other addresses keep their contents.
- R3: A working-word write with `byte_mode_i` = 1 replaces bits 7:0 only, and bits 15:8 keep their old value. With `byte_mode_i` = 0 all 16 bits are replaced.
- R4: When `ien_n_i` is 0 and `dest_sel_i` is 2'b10, the accumulator loads on the rising edge. In byte mode only bits 7:0 load.
- R5: With `ien_n_i` = 1 neither the working words nor the accumulator change, whatever the destination code.
- R6: Destination code 2'b00 (none) and code 2'b11 (reserved) write no storage element. Code 2'b01 leaves the accumulator alone, and code 2'b10 leaves the working words alone.
- R7: When `ien_n_i` = 0, `sen_n_i` = 0 and `nop_i` = 0, the status word loads on the rising edge. The layout is bit0 zero, bit1 carry, bit2 negative, bit3 overflow, and bits 7:4 take `aux_flags_i[3:0]` (link, flag1, flag2, flag3).
- R8: The status word holds when `sen_n_i` = 1, when `ien_n_i` = 1 or when `nop_i` = 1.
- R9: The zero bit is 1 when `result_i[7:0]` is zero in byte mode, or when all of `result_i` is zero in word mode.
- R10: `carry_o` always equals status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| result_i | input | 16 | Result word to store |
| alu_c_i | input | 1 | Carry flag from the arithmetic unit |
| alu_n_i | input | 1 | Negative flag from the arithmetic unit |
| alu_v_i | input | 1 | Overflow flag from the arithmetic unit |
| aux_flags_i | input | 4 | Link and three user flags for status bits 7:4 |
| dest_sel_i | input | 2 | Destination: 00 none, 01 working word, 10 accumulator, 11 none |
| reg_addr_i | input | 5 | Working-word address for write and read |
| byte_mode_i | input | 1 | 1 = byte instruction, 0 = word instruction |
| ien_n_i | input | 1 | Instruction enable, active low |
| sen_n_i | input | 1 | Status enable, active low |
| nop_i | input | 1 | Current instruction is a no-op |
| reg_rd_o | output | 16 | Contents of the addressed working word |
| acc_o | output | 16 | Accumulator value |
| status_o | output | 8 | Status word |
| carry_o | output | 1 | Stored carry for the carry-in selector |

## Verification
Every storage result is due one rising edge after the inputs are presented. The working-word read is combinational, so the read port shows the new value in that same cycle, without a second edge. The bench drives each vector on a falling edge, lets exactly one rising edge pass, and compares the read port, the accumulator, the status word and the carry pin on the next falling edge. It drives the next vector only after that comparison, so no vector is ever applied across two edges.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        DST_NONE = 2'b00,
        DST_REG  = 2'b01,
        DST_ACC  = 2'b10,
        DST_RSVD = 2'b11
    } dest_e;

    // bit 0 is zero; field order sets positions, MSB first
    typedef struct packed {
        logic flag3;
        logic flag2;
        logic flag1;
        logic link;
        logic ovr;
        logic neg;
        logic carry;
        logic zero;
    } status_t;

    localparam int LANE_W = 8;

endpackage

// File: rtl/rfs_regfile.sv
module rfs_regfile
    import rfs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NLANES = DATA_W / LANE_W;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic              lane_we;

        if (g == 0) begin : g_low
            assign lane_we = wr_en;
        end else begin : g_high
            assign lane_we = wr_en && !byte_mode;
        end

        always_ff @(posedge clk) begin
            if (lane_we) begin
                lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[addr];
    end

endmodule

// File: rtl/rfs_accum.sv
module rfs_accum
    import rfs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] acc
);
    localparam int NLANES = DATA_W / LANE_W;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic lane_ld;

        if (g == 0) begin : g_low
            assign lane_ld = ld_en;
        end else begin : g_high
            assign lane_ld = ld_en && !byte_mode;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                acc[g*LANE_W +: LANE_W] <= '0;
            end else if (lane_ld) begin
                acc[g*LANE_W +: LANE_W] <= din[g*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/rfs_status.sv
module rfs_status
    import rfs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] result,
    input  logic              c_in,
    input  logic              n_in,
    input  logic              v_in,
    input  logic [3:0]        aux_in,
    output status_t           stat
);
    status_t next_stat;
    logic    zero_det;

    always_comb begin
        zero_det = byte_mode ? (result[LANE_W-1:0] == '0) : (result == '0);
        next_stat.zero  = zero_det;
        next_stat.carry = c_in;
        next_stat.neg   = n_in;
        next_stat.ovr   = v_in;
        next_stat.link  = aux_in[0];
        next_stat.flag1 = aux_in[1];
        next_stat.flag2 = aux_in[2];
        next_stat.flag3 = aux_in[3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (upd_en) begin
            stat <= next_stat;
        end
    end

endmodule

// File: rtl/rfs_storage.sv
module rfs_storage
    import rfs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] result_i,
    input  logic              alu_c_i,
    input  logic              alu_n_i,
    input  logic              alu_v_i,
    input  logic [3:0]        aux_flags_i,
    input  logic [1:0]        dest_sel_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              byte_mode_i,
    input  logic              ien_n_i,
    input  logic              sen_n_i,
    input  logic              nop_i,
    output logic [DATA_W-1:0] reg_rd_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [7:0]        status_o,
    output logic              carry_o
);
    dest_e   dest;
    logic    wr_reg;
    logic    wr_acc;
    logic    stat_upd;
    status_t stat_q;

    always_comb begin
        dest     = dest_e'(dest_sel_i);
        wr_reg   = 1'b0;
        wr_acc   = 1'b0;
        stat_upd = !ien_n_i && !sen_n_i && !nop_i;
        if (!ien_n_i) begin
            unique case (dest)
                DST_REG:  wr_reg = 1'b1;
                DST_ACC:  wr_acc = 1'b1;
                DST_NONE,
                DST_RSVD: ;
                default:  ;
            endcase
        end
    end

    rfs_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
        .clk       (clk),
        .wr_en     (wr_reg),
        .byte_mode (byte_mode_i),
        .addr      (reg_addr_i),
        .wdata     (result_i),
        .rdata     (reg_rd_o)
    );

    rfs_accum #(.DATA_W(DATA_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (wr_acc),
        .byte_mode (byte_mode_i),
        .din       (result_i),
        .acc       (acc_o)
    );

    rfs_status #(.DATA_W(DATA_W)) u_st (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (stat_upd),
        .byte_mode (byte_mode_i),
        .result    (result_i),
        .c_in      (alu_c_i),
        .n_in      (alu_n_i),
        .v_in      (alu_v_i),
        .aux_in    (aux_flags_i),
        .stat      (stat_q)
    );

    assign status_o = stat_q;
    assign carry_o  = stat_q.carry;

endmodule

// File: rtl/rfs_storage_chk.sv
module rfs_storage_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] result_i,
    input logic              alu_c_i,
    input logic              alu_n_i,
    input logic              alu_v_i,
    input logic [1:0]        dest_sel_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              byte_mode_i,
    input logic              ien_n_i,
    input logic              sen_n_i,
    input logic              nop_i,
    input logic [DATA_W-1:0] reg_rd_o,
    input logic [DATA_W-1:0] acc_o,
    input logic [7:0]        status_o
);
    logic upd;
    assign upd = !ien_n_i && !sen_n_i && !nop_i;

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && status_o == 8'h00));  // R1

    AST_REG_WORD_WR: assert property (@(posedge clk) disable iff (rst)
        (!ien_n_i && dest_sel_i == 2'b01 && !byte_mode_i)
        |=> (!$stable(reg_addr_i) || reg_rd_o == $past(result_i)));  // R2

    AST_REG_BYTE_HI: assert property (@(posedge clk) disable iff (rst)
        (!ien_n_i && dest_sel_i == 2'b01 && byte_mode_i)
        |=> (!$stable(reg_addr_i) || reg_rd_o[DATA_W-1:8] == $past(reg_rd_o[DATA_W-1:8])));  // R3

    AST_ACC_BYTE_HI: assert property (@(posedge clk) disable iff (rst)
        (!ien_n_i && dest_sel_i == 2'b10 && byte_mode_i)
        |=> acc_o[DATA_W-1:8] == $past(acc_o[DATA_W-1:8]));  // R4

    AST_ACC_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        ien_n_i |=> $stable(acc_o));  // R5

    AST_ACC_HOLD_DEST: assert property (@(posedge clk) disable iff (rst)
        (dest_sel_i != 2'b10) |=> $stable(acc_o));  // R6

    AST_STAT_LOAD: assert property (@(posedge clk) disable iff (rst)
        upd |=> status_o[3:1] == {$past(alu_v_i), $past(alu_n_i), $past(alu_c_i)});  // R7

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(status_o));  // R8

    AST_ZERO_BYTE: assert property (@(posedge clk) disable iff (rst)
        (upd && byte_mode_i && result_i[7:0] == 8'h00) |=> status_o[0]);  // R9

endmodule

bind rfs_storage rfs_storage_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .result_i    (result_i),
    .alu_c_i     (alu_c_i),
    .alu_n_i     (alu_n_i),
    .alu_v_i     (alu_v_i),
    .dest_sel_i  (dest_sel_i),
    .reg_addr_i  (reg_addr_i),
    .byte_mode_i (byte_mode_i),
    .ien_n_i     (ien_n_i),
    .sen_n_i     (sen_n_i),
    .nop_i       (nop_i),
    .reg_rd_o    (reg_rd_o),
    .acc_o       (acc_o),
    .status_o    (status_o)
);

// File: tb/tb_rfs_storage.sv
`timescale 1ns/1ps
module tb_rfs_storage;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] result_i;
    logic        alu_c_i, alu_n_i, alu_v_i;
    logic [3:0]  aux_flags_i;
    logic [1:0]  dest_sel_i;
    logic [4:0]  reg_addr_i;
    logic        byte_mode_i, ien_n_i, sen_n_i, nop_i;
    logic [15:0] reg_rd_o, acc_o;
    logic [7:0]  status_o;
    logic        carry_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rfs_storage dut (
        .clk(clk), .rst(rst), .result_i(result_i),
        .alu_c_i(alu_c_i), .alu_n_i(alu_n_i), .alu_v_i(alu_v_i),
        .aux_flags_i(aux_flags_i), .dest_sel_i(dest_sel_i),
        .reg_addr_i(reg_addr_i), .byte_mode_i(byte_mode_i),
        .ien_n_i(ien_n_i), .sen_n_i(sen_n_i), .nop_i(nop_i),
        .reg_rd_o(reg_rd_o), .acc_o(acc_o), .status_o(status_o),
        .carry_o(carry_o)
    );

    typedef struct packed {
        logic [1:0]  dst;
        logic [4:0]  adr;
        logic        byt;
        logic        ienn;
        logic        senn;
        logic        nop;
        logic [15:0] res;
        logic        c;
        logic        n;
        logic        v;
        logic [3:0]  aux;
        logic [15:0] erd;
        logic [15:0] eacc;
        logic [7:0]  est;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        // R2 R7: word write reg3, carry set
        '{2'b01, 5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b0, 1'b0, 4'h0, 16'h1234, 16'h0000, 8'h02},
        // R3 R9: byte write keeps high byte, byte-zero false
        '{2'b01, 5'd3,  1'b1, 1'b0, 1'b0, 1'b0, 16'hABCD, 1'b0, 1'b1, 1'b0, 4'h1, 16'h12CD, 16'h0000, 8'h14},
        // R4 R6 R8: word acc load, status disabled
        '{2'b10, 5'd3,  1'b0, 1'b0, 1'b1, 1'b0, 16'h8001, 1'b1, 1'b1, 1'b1, 4'hF, 16'h12CD, 16'h8001, 8'h14},
        // R4 R9: byte acc load of 00, byte zero set
        '{2'b10, 5'd3,  1'b1, 1'b0, 1'b0, 1'b0, 16'h5500, 1'b0, 1'b0, 1'b1, 4'hA, 16'h12CD, 16'h8000, 8'hA9},
        // R5 R8: instruction disabled
        '{2'b01, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 4'h5, 16'h12CD, 16'h8000, 8'hA9},
        // R6 R8: no destination, no-op
        '{2'b00, 5'd3,  1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b1, 1'b0, 4'h3, 16'h12CD, 16'h8000, 8'hA9},
        // R6 R7: reserved code writes nothing, status loads
        '{2'b11, 5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0F0F, 1'b1, 1'b0, 1'b0, 4'h0, 16'h12CD, 16'h8000, 8'h02},
        // R2 R9: top address, word zero
        '{2'b01, 5'd31, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0000, 16'h8000, 8'hF1},
        // R3 R9: byte write of FF00 keeps hi 00, byte zero though word nonzero
        '{2'b01, 5'd31, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFF00, 1'b1, 1'b0, 1'b0, 4'h0, 16'h0000, 16'h8000, 8'h03},
        // R2 R8: word write, status disabled
        '{2'b01, 5'd3,  1'b0, 1'b0, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b1, 1'b1, 4'hC, 16'h0100, 16'h8000, 8'h03},
        // R4 R9: word acc load of zero
        '{2'b10, 5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 16'h0100, 16'h0000, 8'h01},
        // R8: status enabled but instruction disabled
        '{2'b00, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 16'h4444, 1'b1, 1'b1, 1'b1, 4'hF, 16'h0100, 16'h0000, 8'h01}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        dest_sel_i  = v.dst;
        reg_addr_i  = v.adr;
        byte_mode_i = v.byt;
        ien_n_i     = v.ienn;
        sen_n_i     = v.senn;
        nop_i       = v.nop;
        result_i    = v.res;
        alu_c_i     = v.c;
        alu_n_i     = v.n;
        alu_v_i     = v.v;
        aux_flags_i = v.aux;
    endtask

    initial begin
        rst = 1'b1;
        drive('{2'b00, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0, 8'h0});
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 acc after reset", acc_o, 16'h0000);
        chk("R1 status after reset", {8'h00, status_o}, 16'h0000);
        chk("R10 carry after reset", {15'h0, carry_o}, 16'h0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            chk($sformatf("R2 R3 read vec%0d", i), reg_rd_o, VEC[i].erd);
            chk($sformatf("R4 R5 R6 acc vec%0d", i), acc_o, VEC[i].eacc);
            chk($sformatf("R7 R8 R9 status vec%0d", i), {8'h00, status_o}, {8'h00, VEC[i].est});
            chk($sformatf("R10 carry vec%0d", i), {15'h0, carry_o}, {15'h0, VEC[i].est[1]});
        end

        // R2: two addresses hold distinct words
        drive('{2'b01, 5'd5, 1'b0, 1'b0, 1'b1, 1'b0, 16'hAAAA, 1'b0, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0, 8'h0});
        @(negedge clk);
        drive('{2'b01, 5'd6, 1'b0, 1'b0, 1'b1, 1'b0, 16'h5555, 1'b0, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0, 8'h0});
        @(negedge clk);
        ien_n_i    = 1'b1;
        reg_addr_i = 5'd5;
        #0.5;
        chk("R2 addr5 kept", reg_rd_o, 16'hAAAA);
        reg_addr_i = 5'd6;
        #0.5;
        chk("R2 addr6 read", reg_rd_o, 16'h5555);

        // R1: reset wins over a simultaneous accumulator and status write
        @(negedge clk);
        drive('{2'b10, 5'd6, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7777, 1'b1, 1'b1, 1'b1, 4'hF, 16'h0, 16'h0, 8'h0});
        rst = 1'b1;
        @(negedge clk);
        chk("R1 acc reset priority", acc_o, 16'h0000);
        chk("R1 status reset priority", {8'h00, status_o}, 16'h0000);
        chk("R10 carry reset priority", {15'h0, carry_o}, 16'h0000);
        rst     = 1'b0;
        ien_n_i = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule